// File: doc/BRIEF.md
# Masked Vector Execution Unit

This block executes one vector operation at a time on a set of signed 16-bit elements held side by side in flat operand buses. A per-element mask register decides which elements an operation may change. Compare operations rewrite the mask: one bit per element, from a zero test, a non-zero test or a signed greater-or-equal test of A against B. A complement operation inverts the mask. The add, multiply and move operations then write only those destination elements whose mask bit is set. An if/else select is built from four operations in sequence: a compare, a masked move of A, a complement, and a masked move of B.

Arithmetic work is sequential, one element per cycle. Two schedules are selectable per operation. The gated schedule visits every element below the active length and suppresses the write where the mask bit is clear. The skipping schedule visits only the elements whose mask bit is set, so its cycle count follows the number of set bits. The active length limits every operation. The destination vector and the mask are held in registers and are visible on the ports at all times.

Top module: `mvec_unit`

## Requirements
- R1: After reset, busy, done and wr_en are 0, and every bit of mask and dest is 0.
- R2: Opcode 3 sets mask bit i to (A[i]==0), opcode 4 to (A[i]!=0) and opcode 5 to (signed A[i] >= signed B[i]), for every i below the active length. Mask bits at or above the length become 0. Each compare keeps busy high for exactly one cycle and writes no destination element.
- R3: Opcode 6 inverts mask bits below the active length and clears the bits above it, in one busy cycle.
- R4: Opcode 0 writes A[i]+B[i] and opcode 1 writes the low 16 bits of A[i]*B[i] into dest element i (bits 16*i+15 to 16*i) only when mask bit i is 1 and i is below the active length. Both wrap modulo 2^16.
- R5: A destination element whose mask bit is 0, or whose index is at or above the active length, keeps its previous value.
- R6: With skip_mode=0 an arithmetic operation is busy for max(L,1) cycles, where L is the active length. In busy cycle k (counting from 0), wr_en equals 1<<k if mask bit k is set, and 0 otherwise.
- R7: With skip_mode=1 an arithmetic operation is busy for max(P,1) cycles, where P is the number of set mask bits below the active length. Each busy cycle raises one wr_en bit, in ascending index order. An all-zero mask gives one busy cycle with no write.
- R8: done is high for exactly one cycle, in the cycle after the last busy cycle. A start while busy is high is ignored.
- R9: A vlen value above the element count acts as the full element count.
- R10: Opcode 2 copies A[i] into dest element i under the same mask and length rules. The sequence compare-GE, masked move of A, complement, masked move of B leaves max(A[i],B[i]) in every element below the length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Begin an operation; accepted only when busy is 0 |
| opcode | input | 3 | 0 add, 1 multiply, 2 move A, 3 A==0, 4 A!=0, 5 A>=B, 6 complement mask, 7 no-op |
| skip_mode | input | 1 | 0 gated schedule, 1 skipping schedule |
| vlen | input | 4 | Active vector length, 0 to 15, clamped to 8 |
| src_a | input | 128 | Operand A, element i at bits 16*i+15 to 16*i |
| src_b | input | 128 | Operand B, same layout |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_en | output | 8 | Destination element written at the end of this cycle |
| mask | output | 8 | Current mask register |
| dest | output | 128 | Destination vector register, same layout as A |

## Verification
A corrupted pending-element set shows up on wr_en in the same cycle: an element is skipped, repeated or taken out of order. It also shows as a busy count that differs from the length or from the population count, which the bench measures on every operation. A wrong mask or destination bit is visible on the ports at the end of the operation that made it. The bench compares both registers after every operation, so an error is seen before the next start. The if/else select sequence ties compare, complement and move together, so a fault in one of them gives wrong maxima.

// File: rtl/mvec_pkg.sv
package mvec_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_MUL  = 3'd1,
    OP_MOV  = 3'd2,
    OP_CEQZ = 3'd3,
    OP_CNEZ = 3'd4,
    OP_CGE  = 3'd5,
    OP_MNOT = 3'd6,
    OP_NOP  = 3'd7
  } vop_e;

  function automatic logic is_arith(vop_e op);
    return (op == OP_ADD) || (op == OP_MUL) || (op == OP_MOV);
  endfunction

  function automatic logic is_mask_op(vop_e op);
    return (op == OP_CEQZ) || (op == OP_CNEZ) || (op == OP_CGE) || (op == OP_MNOT);
  endfunction
endpackage

// File: rtl/mvec_rst_sync.sv
module mvec_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/mvec_pick.sv
module mvec_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          last
);
  // lowest set bit isolation
  assign grant = req & (~req + N'(1));
  assign last  = ((req & ~grant) == '0);

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/mvec_elem_alu.sv
module mvec_elem_alu
  import mvec_pkg::*;
#(
  parameter int W = 16
) (
  input  vop_e         op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_MUL:  y = a * b;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/mvec_cmp_bank.sv
module mvec_cmp_bank
  import mvec_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 16
) (
  input  vop_e           op,
  input  logic [N*W-1:0] a_vec,
  input  logic [N*W-1:0] b_vec,
  input  logic [N-1:0]   mask_cur,
  input  logic [N-1:0]   len_mask,
  output logic [N-1:0]   mask_new
);
  for (genvar g = 0; g < N; g++) begin : g_elem
    logic signed [W-1:0] ea, eb;
    logic                bit_v;
    assign ea = a_vec[g*W +: W];
    assign eb = b_vec[g*W +: W];
    always_comb begin
      case (op)
        OP_CEQZ: bit_v = (ea == '0);
        OP_CNEZ: bit_v = (ea != '0);
        OP_CGE:  bit_v = (ea >= eb);
        OP_MNOT: bit_v = ~mask_cur[g];
        default: bit_v = mask_cur[g];
      endcase
    end
    assign mask_new[g] = len_mask[g] & bit_v;
  end
endmodule

// File: rtl/mvec_unit.sv
module mvec_unit
  import mvec_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [2:0]                 opcode,
  input  logic                       skip_mode,
  input  logic [$clog2(N+1)-1:0]     vlen,
  input  logic [N*W-1:0]             src_a,
  input  logic [N*W-1:0]             src_b,
  output logic                       busy,
  output logic                       done,
  output logic [N-1:0]               wr_en,
  output logic [N-1:0]               mask,
  output logic [N*W-1:0]             dest
);
  localparam int LW = $clog2(N+1);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic rst_ns;
  mvec_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ns));

  // state registers
  logic           busy_q, done_q;
  vop_e           op_q;
  logic [N*W-1:0] a_q, b_q;
  logic [N-1:0]   len_mask_q, pend_q, mask_q;
  logic [W-1:0]   dest_q [N];

  // next-state signals
  logic           busy_d, done_d;
  logic [N-1:0]   pend_d;
  logic           start_acc, ctl_en, mask_en;
  vop_e           op_in;
  logic [LW-1:0]  len_eff;
  logic [N-1:0]   len_mask_in, pend_load, mask_new;
  logic [N-1:0]   grant;
  logic [IW-1:0]  idx;
  logic           last;
  logic [W-1:0]   alu_y;

  assign op_in     = vop_e'(opcode);
  assign start_acc = start & ~busy_q;
  assign len_eff   = (vlen > LW'(N)) ? LW'(N) : vlen;

  for (genvar g = 0; g < N; g++) begin : g_len
    assign len_mask_in[g] = (int'(len_eff) > g);
  end

  always_comb begin
    if (!is_arith(op_in))  pend_load = '0;
    else if (skip_mode)    pend_load = len_mask_in & mask_q;
    else                   pend_load = len_mask_in;
  end

  mvec_pick #(.N(N), .IW(IW)) u_pick (
    .req(pend_q), .grant(grant), .idx(idx), .last(last)
  );

  mvec_elem_alu #(.W(W)) u_alu (
    .op(op_q), .a(a_q[idx*W +: W]), .b(b_q[idx*W +: W]), .y(alu_y)
  );

  mvec_cmp_bank #(.N(N), .W(W)) u_cmp (
    .op(op_q), .a_vec(a_q), .b_vec(b_q), .mask_cur(mask_q),
    .len_mask(len_mask_q), .mask_new(mask_new)
  );

  assign wr_en   = (busy_q && is_arith(op_q)) ? (grant & mask_q) : '0;
  assign mask_en = busy_q && is_mask_op(op_q);
  assign ctl_en  = start_acc | busy_q | done_q;

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    pend_d = pend_q;
    if (start_acc) begin
      busy_d = 1'b1;
      pend_d = pend_load;
    end else if (busy_q) begin
      pend_d = pend_q & ~grant;
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pend_q <= '0;
    end else if (ctl_en) begin
      busy_q <= busy_d;
      done_q <= done_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      op_q       <= OP_NOP;
      len_mask_q <= '0;
    end else if (start_acc) begin
      op_q       <= op_in;
      len_mask_q <= len_mask_in;
    end
  end

  always_ff @(posedge clk) begin
    if (start_acc) begin
      a_q <= src_a;
      b_q <= src_b;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)      mask_q <= '0;
    else if (mask_en) mask_q <= mask_new;
  end

  for (genvar g = 0; g < N; g++) begin : g_dest
    always_ff @(posedge clk or negedge rst_ns) begin
      if (!rst_ns)       dest_q[g] <= '0;
      else if (wr_en[g]) dest_q[g] <= alu_y;
    end
    assign dest[g*W +: W] = dest_q[g];
  end

  assign busy = busy_q;
  assign done = done_q;
  assign mask = mask_q;
endmodule

// File: rtl/mvec_unit_chk.sv
module mvec_unit_chk #(
  parameter int N = 8,
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [N-1:0]   wr_en,
  input logic [N-1:0]   mask,
  input logic [N*W-1:0] dest
);
  a_r6_wr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));

  a_r4_wr_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en & ~mask) == '0);

  a_r8_wr_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en != '0) |-> busy);

  a_r5_dest_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en == '0) |=> $stable(dest));

  a_r2_mask_hold_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en != '0) |=> $stable(mask));

  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  a_r8_fall_gives_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r8_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind mvec_unit mvec_unit_chk #(.N(N), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .wr_en(wr_en), .mask(mask), .dest(dest)
);

// File: tb/mvec_unit_tb.sv
module mvec_unit_tb;
  localparam int N = 8;
  localparam int W = 16;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           start;
  logic [2:0]     opcode;
  logic           skip_mode;
  logic [3:0]     vlen;
  logic [N*W-1:0] src_a, src_b;
  logic           busy, done;
  logic [N-1:0]   wr_en, mask;
  logic [N*W-1:0] dest;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  logic [W-1:0] rdest [N];
  logic [N-1:0] rmask;

  always #5 clk = ~clk;

  mvec_unit #(.N(N), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .skip_mode(skip_mode), .vlen(vlen), .src_a(src_a), .src_b(src_b),
    .busy(busy), .done(done), .wr_en(wr_en), .mask(mask), .dest(dest)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [N*W-1:0] ref_dest_flat();
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = rdest[i];
    return v;
  endfunction

  function automatic logic [W-1:0] elt(input logic [N*W-1:0] v, input int i);
    return v[i*W +: W];
  endfunction

  task automatic do_op(input logic [2:0] op, input bit skip, input int len,
                       input logic [N*W-1:0] a, input logic [N*W-1:0] b,
                       input bit hold, input string tag);
    int eff, exp_n, n;
    logic [N-1:0] exp_seq [16];
    logic [N-1:0] got_seq [16];
    bit seq_bad;
    logic [N-1:0] lm;
    eff = (len > N) ? N : len;
    lm = '0;
    for (int i = 0; i < eff; i++) lm[i] = 1'b1;
    exp_n = 0;
    if (op <= 3'd2) begin
      for (int i = 0; i < eff; i++) begin
        if (skip) begin
          if (rmask[i]) begin exp_seq[exp_n] = N'(1) << i; exp_n++; end
        end else begin
          exp_seq[exp_n] = rmask[i] ? (N'(1) << i) : '0; exp_n++;
        end
      end
    end
    if (exp_n == 0) begin exp_seq[0] = '0; exp_n = 1; end

    @(negedge clk);
    opcode = op; skip_mode = skip; vlen = len[3:0];
    src_a = a; src_b = b; start = 1'b1;
    @(negedge clk);
    if (hold) opcode = 3'd6; else start = 1'b0;
    n = 0; seq_bad = 0;
    while (busy && n < 40) begin
      if (n < 16) got_seq[n] = wr_en;
      if (n < 16 && n < exp_n && wr_en !== exp_seq[n]) seq_bad = 1;
      n++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(n == exp_n, tag, "busy cycles", N*W'(n), N*W'(exp_n));
    chk(!seq_bad, tag, "wr_en sequence first entry", N*W'(got_seq[0]), N*W'(exp_seq[0]));
    chk(done === 1'b1, "R8", "done after last busy", N*W'(done), N*W'(1));

    // reference update
    case (op)
      3'd0, 3'd1, 3'd2: begin
        for (int i = 0; i < eff; i++) begin
          if (rmask[i]) begin
            if (op == 3'd0)      rdest[i] = elt(a, i) + elt(b, i);
            else if (op == 3'd1) rdest[i] = elt(a, i) * elt(b, i);
            else                 rdest[i] = elt(a, i);
          end
        end
      end
      3'd3: for (int i = 0; i < N; i++) rmask[i] = lm[i] & (elt(a, i) == '0);
      3'd4: for (int i = 0; i < N; i++) rmask[i] = lm[i] & (elt(a, i) != '0);
      3'd5: for (int i = 0; i < N; i++)
              rmask[i] = lm[i] & ($signed(elt(a, i)) >= $signed(elt(b, i)));
      3'd6: rmask = lm & ~rmask;
      default: ;
    endcase
    chk(dest === ref_dest_flat(), (op <= 3'd2) ? "R4 R5" : "R5",
        "dest vector", dest, ref_dest_flat());
    chk(mask === rmask, (op == 3'd6) ? "R3" : "R2", "mask register",
        N*W'(mask), N*W'(rmask));
    @(negedge clk);
    chk(done === 1'b0, "R8", "done single cycle", N*W'(done), '0);
  endtask

  function automatic logic [N*W-1:0] rnd_vec(input bit zeros);
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++)
      v[i*W +: W] = (zeros && ($urandom % 3 == 0)) ? '0 : W'($urandom);
    return v;
  endfunction

  initial begin
    logic [N*W-1:0] va, vb, vmax;
    void'($urandom(32'd4471));
    rst_n = 1'b0; start = 1'b0; opcode = '0; skip_mode = 1'b0;
    vlen = '0; src_a = '0; src_b = '0;
    for (int i = 0; i < N; i++) rdest[i] = '0;
    rmask = '0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(busy === 1'b0 && done === 1'b0 && wr_en === '0, "R1", "control outputs",
        N*W'({busy, done, wr_en}), '0);
    chk(mask === '0, "R1", "mask", N*W'(mask), '0);
    chk(dest === '0, "R1", "dest", dest, '0);

    // R2 compare not-zero on full length, then R6 gated add
    va = rnd_vec(1); vb = rnd_vec(0);
    do_op(3'd4, 1'b0, 8, va, vb, 1'b0, "R2");
    do_op(3'd0, 1'b0, 8, va, vb, 1'b0, "R6");
    // R7 skipping multiply with the same mask
    do_op(3'd1, 1'b1, 8, rnd_vec(0), rnd_vec(0), 1'b0, "R7");
    // R3 complement at short length clears upper bits
    do_op(3'd6, 1'b0, 5, '0, '0, 1'b0, "R3");
    // R7 all-zero mask: compare eqz on non-zero data, then skipping add
    va = '0;
    for (int i = 0; i < N; i++) va[i*W +: W] = W'(i + 1);
    do_op(3'd3, 1'b0, 8, va, '0, 1'b0, "R2");
    do_op(3'd0, 1'b1, 8, rnd_vec(0), rnd_vec(0), 1'b0, "R7");
    // R6 length zero gated: one cycle, no write
    do_op(3'd6, 1'b0, 8, '0, '0, 1'b0, "R3");
    do_op(3'd0, 1'b0, 0, rnd_vec(0), rnd_vec(0), 1'b0, "R6");
    // R9 length above element count clamps
    do_op(3'd6, 1'b0, 15, '0, '0, 1'b0, "R9");
    do_op(3'd2, 1'b0, 12, rnd_vec(0), '0, 1'b0, "R9");
    // R8 start held high while busy is ignored (opcode switched to complement)
    do_op(3'd0, 1'b0, 8, rnd_vec(0), rnd_vec(0), 1'b1, "R8");

    // R10 if/else select: max(A,B) over 6 elements
    va = rnd_vec(0); vb = rnd_vec(0);
    va[2*W +: W] = vb[2*W +: W];
    do_op(3'd5, 1'b0, 6, va, vb, 1'b0, "R10");
    do_op(3'd2, 1'b1, 6, va, '0, 1'b0, "R10");
    do_op(3'd6, 1'b0, 6, '0, '0, 1'b0, "R10");
    do_op(3'd2, 1'b0, 6, vb, '0, 1'b0, "R10");
    for (int i = 0; i < 6; i++) begin
      vmax[i*W +: W] = ($signed(elt(va, i)) >= $signed(elt(vb, i))) ? elt(va, i) : elt(vb, i);
      chk(elt(dest, i) === vmax[i*W +: W], "R10", "select max element",
          N*W'(elt(dest, i)), N*W'(vmax[i*W +: W]));
    end

    // random mix
    for (int k = 0; k < 60; k++) begin
      logic [2:0] op;
      bit sk;
      int ln;
      op = 3'($urandom % 7);
      sk = 1'($urandom % 2);
      ln = $urandom % 11;
      do_op(op, sk, ln, rnd_vec(op == 3'd3 || op == 3'd4), rnd_vec(0), 1'b0,
            (op <= 3'd2) ? (sk ? "R7" : "R6") : ((op == 3'd6) ? "R3" : "R2"));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule